// File: doc/BRIEF.md
# Set-Indexed Address Translation Buffer

This block translates virtual effective addresses into physical addresses for one side of a processor pipeline. It is a small array of entries indexed by the low bits of the virtual page number. Each entry is built from two words. The match word holds the virtual page number, a valid flag and a replacement hint. The translate word holds the physical page number, a cache-inhibit flag and six permission flags: read, write and execute for supervisor mode, and the same three for user mode. One array type serves both the data side and the instruction side; each side simply leaves the flags it does not use at zero.

Each request carries an address, an access kind and a privilege flag. One cycle later the block returns a registered result: either a physical address, or a miss flag, or a permission-fault flag. Misses and faults are reported separately so that each can raise its own exception. On either one, the full faulting address is captured in a holding register for the handler. Software fills and clears entries through a simple write port, one word per write. A combinational output names the first way in a chosen set whose replacement hint is clear, so the handler can pick a refill target. When translation is switched off, addresses pass through unchanged.

Top module: `tlb_xlat`

## Requirements
- R1: Pages are 8 KiB. On a hit, result address bits [12:0] equal request bits [12:0], and bits [31:13] come from the entry's physical page number.
- R2: The set is chosen by the page number modulo SETS, which is request bits [17:13] for 32 sets. An entry written to one set never hits a request whose page falls in another set.
- R3: A way hits only when its valid flag (match word bit 0) is set and its stored page number (match word bits [31:13]) equals the request's page number. If no way hits, `rspMiss` is set and `rspPhys` is zero. When several ways hit, the lowest-numbered way is used.
- R4: The access kinds are read = 0, write = 1 and execute = 2. The translate-word flags are bit 1 supervisor read, bit 2 supervisor write, bit 3 user read, bit 4 user write, bit 5 supervisor execute and bit 6 user execute; `reqSuper` = 1 selects supervisor mode. A hit whose flag for this kind and mode is clear sets `rspFault` with `rspPhys` zero; kind 3 always faults. `rspMiss` and `rspFault` are never both set.
- R5: When a result reports a miss or a fault, `faultAddr` holds the full request address from that same cycle. At all other times `faultAddr` keeps its value. It resets to zero.
- R6: Writing zero to an entry's match word makes it invalid, so later lookups of that page miss.
- R7: `refillWay` names the lowest way in set `swSet` whose replacement hint (match word bit 1) is clear, and names 0 when every way's hint is set.
- R8: While `xlatEn` is low, `rspPhys` equals the request address, `rspMiss`, `rspFault` and `rspInhibit` are zero, and `faultAddr` does not change.
- R9: `rspValid` goes high in the cycle after each `reqValid` and only then. A lookup sees the array as it was before any write made in the same cycle. A write is seen by every later lookup.
- R10: On a translated hit, `rspInhibit` equals bit 0 of the entry's translate word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlatEn | input | 1 | Translation enable |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | ADDR_W | Virtual effective address |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqSuper | input | 1 | 1 = supervisor mode, 0 = user mode |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspPhys | output | ADDR_W | Physical address (zero on miss or fault) |
| rspMiss | output | 1 | No valid matching entry |
| rspFault | output | 1 | Hit without the needed permission |
| rspInhibit | output | 1 | Cache-inhibit flag of the hit entry |
| faultAddr | output | ADDR_W | Captured address of the last miss or fault |
| swWrEn | input | 1 | Entry write strobe |
| swSelXlat | input | 1 | 0 = write match word, 1 = write translate word |
| swWay | input | WAY_W | Way to write |
| swSet | input | SET_W | Set to write; also the set for the refill query |
| swData | input | ADDR_W | Word written |
| refillWay | output | WAY_W | First way in `swSet` whose replacement hint is clear |

## Verification
The assertions assume that `reqKind`, `reqSuper` and `reqAddr` stay steady for the whole cycle in which `reqValid` is high. They also assume that `swWay` never points past the last way. The bench drives every input on the falling edge, holds each request for exactly one cycle, and uses only way numbers below the configured count. Some checks rely on a lookup and a write to the same entry in the same cycle. For those, the bench drives both strobes at the same falling edge, so the ordering is fixed by the design and not by how the bench is scheduled.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } accKind_t;

  // translate-word flag positions
  localparam int ATTR_INH  = 0;
  localparam int ATTR_SR   = 1;
  localparam int ATTR_SW   = 2;
  localparam int ATTR_UR   = 3;
  localparam int ATTR_UW   = 4;
  localparam int ATTR_SX   = 5;
  localparam int ATTR_UX   = 6;
  localparam int ATTR_W    = 7;

  // match-word flag positions
  localparam int MATCH_VLD = 0;
  localparam int MATCH_LRU = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRsp;
    logic passThru;
    logic flagMiss;
    logic flagFault;
    logic captureEa;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_dpath.sv
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SETS      = 32,
  parameter int WAYS      = 1,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  tlbStrobe_t        strb,
  input  logic              swWrEn,
  input  logic              swSelXlat,
  input  logic [WAY_W-1:0]  swWay,
  input  logic [SET_W-1:0]  swSet,
  input  logic [ADDR_W-1:0] swData,
  output logic              hitAny,
  output logic [ATTR_W-1:1] hitPerm,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspInhibit,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [WAY_W-1:0]  refillWay
);

  logic [VPN_W-1:0]  vpnMem  [WAYS][SETS];
  logic [VPN_W-1:0]  ppnMem  [WAYS][SETS];
  logic [ATTR_W-1:0] attrMem [WAYS][SETS];
  logic              vldMem  [WAYS][SETS];
  logic              lruMem  [WAYS][SETS];

  logic [VPN_W-1:0]  reqPage;
  logic [SET_W-1:0]  reqSet;
  logic [WAYS-1:0]   wayHit;
  logic [VPN_W-1:0]  selPpn;
  logic [ATTR_W-1:0] selAttr;

  assign reqPage = reqAddr[ADDR_W-1:PAGE_BITS];
  assign reqSet  = reqPage[SET_W-1:0];

  // storage, one generate slice per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) begin
          vldMem[w][s] <= 1'b0;
          lruMem[w][s] <= 1'b0;
        end
      end else if (swWrEn && !swSelXlat && swWay == WAY_W'(w)) begin
        vldMem[w][swSet] <= swData[MATCH_VLD];
        lruMem[w][swSet] <= swData[MATCH_LRU];
      end
    end

    always_ff @(posedge clk) begin
      if (swWrEn && swWay == WAY_W'(w)) begin
        if (swSelXlat) begin
          ppnMem[w][swSet]  <= swData[ADDR_W-1:PAGE_BITS];
          attrMem[w][swSet] <= swData[ATTR_W-1:0];
        end else begin
          vpnMem[w][swSet]  <= swData[ADDR_W-1:PAGE_BITS];
        end
      end
    end

    assign wayHit[w] = vldMem[w][reqSet] && (vpnMem[w][reqSet] == reqPage);
  end

  // lowest hitting way wins
  always_comb begin
    selPpn  = '0;
    selAttr = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) begin
        selPpn  = ppnMem[w][reqSet];
        selAttr = attrMem[w][reqSet];
      end
    end
  end

  assign hitAny  = |wayHit;
  assign hitPerm = selAttr[ATTR_W-1:1];

  // refill choice: lowest way with clear hint
  always_comb begin
    refillWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!lruMem[w][swSet]) refillWay = WAY_W'(w);
    end
  end

  // registered result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspPhys    <= '0;
      rspMiss    <= 1'b0;
      rspFault   <= 1'b0;
      rspInhibit <= 1'b0;
    end else begin
      rspValid <= strb.loadRsp;
      if (strb.loadRsp) begin
        rspMiss    <= strb.flagMiss;
        rspFault   <= strb.flagFault;
        if (strb.passThru) begin
          rspPhys    <= reqAddr;
          rspInhibit <= 1'b0;
        end else if (strb.flagMiss || strb.flagFault) begin
          rspPhys    <= '0;
          rspInhibit <= 1'b0;
        end else begin
          rspPhys    <= {selPpn, reqAddr[PAGE_BITS-1:0]};
          rspInhibit <= selAttr[ATTR_INH];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              faultAddr <= '0;
    else if (strb.captureEa) faultAddr <= reqAddr;
  end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic              xlatEn,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqSuper,
  input  logic              hitAny,
  input  logic [ATTR_W-1:1] hitPerm,
  output tlbStrobe_t        strb
);

  logic permOk;

  always_comb begin
    unique case (accKind_t'(reqKind))
      ACC_READ:  permOk = reqSuper ? hitPerm[ATTR_SR] : hitPerm[ATTR_UR];
      ACC_WRITE: permOk = reqSuper ? hitPerm[ATTR_SW] : hitPerm[ATTR_UW];
      ACC_EXEC:  permOk = reqSuper ? hitPerm[ATTR_SX] : hitPerm[ATTR_UX];
      default:   permOk = 1'b0;
    endcase
  end

  always_comb begin
    strb.loadRsp   = reqValid;
    strb.passThru  = !xlatEn;
    strb.flagMiss  = xlatEn && !hitAny;
    strb.flagFault = xlatEn && hitAny && !permOk;
    strb.captureEa = reqValid && xlatEn && !(hitAny && permOk);
  end

endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SETS      = 32,
  parameter int WAYS      = 1,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlatEn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqSuper,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspInhibit,
  output logic [ADDR_W-1:0] faultAddr,
  input  logic              swWrEn,
  input  logic              swSelXlat,
  input  logic [WAY_W-1:0]  swWay,
  input  logic [SET_W-1:0]  swSet,
  input  logic [ADDR_W-1:0] swData,
  output logic [WAY_W-1:0]  refillWay
);

  tlbStrobe_t        strb;
  logic              hitAny;
  logic [ATTR_W-1:1] hitPerm;

  tlb_ctrl u_ctrl (
    .xlatEn   (xlatEn),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqSuper (reqSuper),
    .hitAny   (hitAny),
    .hitPerm  (hitPerm),
    .strb     (strb)
  );

  tlb_dpath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .SETS      (SETS),
    .WAYS      (WAYS)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqAddr    (reqAddr),
    .strb       (strb),
    .swWrEn     (swWrEn),
    .swSelXlat  (swSelXlat),
    .swWay      (swWay),
    .swSet      (swSet),
    .swData     (swData),
    .hitAny     (hitAny),
    .hitPerm    (hitPerm),
    .rspValid   (rspValid),
    .rspPhys    (rspPhys),
    .rspMiss    (rspMiss),
    .rspFault   (rspFault),
    .rspInhibit (rspInhibit),
    .faultAddr  (faultAddr),
    .refillWay  (refillWay)
  );

endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int WAYS      = 1,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlatEn,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspPhys,
  input logic              rspMiss,
  input logic              rspFault,
  input logic              rspInhibit,
  input logic [ADDR_W-1:0] faultAddr,
  input logic [WAY_W-1:0]  refillWay
);

  // R9: a result follows each request by one cycle
  p_rsp_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  // R4: miss and fault are exclusive
  p_miss_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !(rspMiss && rspFault));

  // R3: an error result carries no address
  p_err_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && (rspMiss || rspFault) |-> rspPhys == '0 && !rspInhibit);

  // R1: page offset untouched on a translated hit
  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && xlatEn |=>
      (rspMiss || rspFault || rspPhys[PAGE_BITS-1:0] == $past(reqAddr[PAGE_BITS-1:0])));

  // R8: bypass when translation is off
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !xlatEn |=> rspPhys == $past(reqAddr) && !rspMiss && !rspFault && !rspInhibit);

  // R5: capture on error, hold otherwise
  p_ea_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && (rspMiss || rspFault) |-> faultAddr == $past(reqAddr));
  p_ea_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rspValid && (rspMiss || rspFault)) |-> $stable(faultAddr));

  // R7: refill choice stays inside the array
  p_refill_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(refillWay) < WAYS);

endmodule

bind tlb_xlat tlb_xlat_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS),
  .WAYS      (WAYS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xlatEn     (xlatEn),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .rspValid   (rspValid),
  .rspPhys    (rspPhys),
  .rspMiss    (rspMiss),
  .rspFault   (rspFault),
  .rspInhibit (rspInhibit),
  .faultAddr  (faultAddr),
  .refillWay  (refillWay)
);

// File: tb/sim_tlb_xlat.sv
module sim_tlb_xlat;

  localparam int ADDR_W = 32;
  localparam int SETS   = 32;
  localparam int WAYS   = 2;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              xlatEn = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqKind = 2'd0;
  logic              reqSuper = 1'b0;
  logic              rspValid;
  logic [ADDR_W-1:0] rspPhys;
  logic              rspMiss;
  logic              rspFault;
  logic              rspInhibit;
  logic [ADDR_W-1:0] faultAddr;
  logic              swWrEn = 1'b0;
  logic              swSelXlat = 1'b0;
  logic [WAY_W-1:0]  swWay = '0;
  logic [SET_W-1:0]  swSet = '0;
  logic [ADDR_W-1:0] swData = '0;
  logic [WAY_W-1:0]  refillWay;

  always #5 clk = ~clk;

  tlb_xlat #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u0 (.*);

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] phys;
    logic              miss;
    logic              fault;
    logic              inh;
    string             tag;
  } expItem_t;

  expItem_t          sbq[$];
  int                nRun = 0;
  int                nFail = 0;
  logic [ADDR_W-1:0] expEa = '0;
  bit                done = 1'b0;

  task automatic chk(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per result
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      if (sbq.size() == 0) begin
        chk("R9 unexpected result", 32'd1, 32'd0);
      end else begin
        expItem_t it;
        it = sbq.pop_front();
        if (it.miss || it.fault) expEa = it.addr;
        chk({it.tag, " phys"},  rspPhys, it.phys);
        chk({it.tag, " miss"},  32'(rspMiss), 32'(it.miss));
        chk({it.tag, " fault"}, 32'(rspFault), 32'(it.fault));
        chk({it.tag, " inh"},   32'(rspInhibit), 32'(it.inh));
        chk({it.tag, " R5 faultAddr"}, faultAddr, expEa);
      end
    end
  end

  // driver: one-cycle request, optional same-cycle entry write
  task automatic lookup(input logic [ADDR_W-1:0] a, input logic [1:0] k, input logic sup,
                        input logic [ADDR_W-1:0] ph, input logic m, input logic f,
                        input logic inh, input string tag);
    expItem_t it;
    it.addr = a; it.phys = ph; it.miss = m; it.fault = f; it.inh = inh; it.tag = tag;
    sbq.push_back(it);
    reqValid = 1'b1; reqAddr = a; reqKind = k; reqSuper = sup;
    @(negedge clk);
    reqValid = 1'b0; swWrEn = 1'b0;
  endtask

  task automatic wr(input logic sel, input int way, input int set, input logic [ADDR_W-1:0] d);
    swWrEn = 1'b1; swSelXlat = sel; swWay = WAY_W'(way); swSet = SET_W'(set); swData = d;
    @(negedge clk);
    swWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset rspValid", 32'(rspValid), 32'd0);
    chk("R5 reset faultAddr", faultAddr, 32'd0);
    rst_n = 1'b1;
    xlatEn = 1'b1;
    @(negedge clk);

    // R3/R5: empty array misses
    lookup(32'h0000_4123, 2'd0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, "R3 empty miss");
    // fill way0 set2: page 2 -> 0x12346, inhibit + supervisor read
    wr(1'b0, 0, 2, 32'h0000_4001);
    wr(1'b1, 0, 2, 32'h1234_6003);
    lookup(32'h0000_4123, 2'd0, 1'b1, 32'h1234_6123, 1'b0, 1'b0, 1'b1, "R1 R9 R10 hit read");
    lookup(32'h0000_4ABC, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R4 user read fault");
    lookup(32'h0000_4008, 2'd1, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R4 super write fault");
    lookup(32'h0000_5FFC, 2'd0, 1'b1, 32'h1234_7FFC, 1'b0, 1'b0, 1'b1, "R1 top offset hit");
    lookup(32'h0000_6000, 2'd0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, "R2 other set miss");
    lookup(32'h0004_4010, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R3 vpn mismatch miss");
    lookup(32'h0000_4010, 2'd3, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R4 kind3 fault");
    // way1 set2: page 34 (same set by modulo), user execute only
    wr(1'b0, 1, 2, 32'h0004_4001);
    wr(1'b1, 1, 2, 32'hABCD_0040);
    lookup(32'h0004_4010, 2'd2, 1'b0, 32'hABCD_0010, 1'b0, 1'b0, 1'b0, "R2 modulo hit exec");
    lookup(32'h0004_4014, 2'd2, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R4 super exec fault");
    lookup(32'h0004_4018, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R4 user read fault");
    // R9: invalidate in same cycle as lookup; lookup still sees old entry
    swWrEn = 1'b1; swSelXlat = 1'b0; swWay = 1'b1; swSet = 5'd2; swData = 32'h0;
    lookup(32'h0004_4020, 2'd2, 1'b0, 32'hABCD_0020, 1'b0, 1'b0, 1'b0, "R9 same-cycle write");
    wr(1'b1, 1, 2, 32'h0);
    lookup(32'h0004_4024, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R6 invalidated miss");
    // R8 bypass
    xlatEn = 1'b0;
    lookup(32'h0004_4030, 2'd1, 1'b0, 32'h0004_4030, 1'b0, 1'b0, 1'b0, "R8 bypass");
    lookup(32'h0000_6000, 2'd3, 1'b0, 32'h0000_6000, 1'b0, 1'b0, 1'b0, "R8 bypass kind3");
    xlatEn = 1'b1;
    @(negedge clk);
    // R7 refill choice in set 5
    swSet = 5'd5; #1;
    chk("R7 none hinted", 32'(refillWay), 32'd0);
    @(negedge clk);
    wr(1'b0, 0, 5, 32'h0000_0002);
    swSet = 5'd5; #1;
    chk("R7 way0 hinted", 32'(refillWay), 32'd1);
    @(negedge clk);
    wr(1'b0, 1, 5, 32'h0000_0002);
    swSet = 5'd5; #1;
    chk("R7 all hinted", 32'(refillWay), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 queue drained", 32'(sbq.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule